// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a binary counter, four bits wide by default, that counts on two separate count-clock inputs: one steps the value up, the other steps it down. Both count clocks are treated as ordinary data signals. They are synchronised to a fast system clock, and their rising edges are found by comparing each sample with the one before it. A master clear forces the count to zero, and an active-low load copies a data word into the counter. Both are level controls and take effect at once, ahead of any counting.

Two active-low terminal outputs follow the low phase of the matching count clock. The up terminal does so while the count is at its maximum, and the down terminal while the count is zero. A second instance can therefore take these outputs directly as its own up and down clocks, giving a wider ripple-cascaded counter. If both count clocks show a rising edge in the same system cycle, the count holds and a one-cycle clash flag is raised.

Top module: `updn_ctr`

## Requirements
- R1: A rising edge on `up_clk_i` while `dn_clk_i` is high adds one to the count. 15 steps to 0.
- R2: A rising edge on `dn_clk_i` while `up_clk_i` is high subtracts one from the count. 0 steps to 15.
- R3: While `clr_i` is high, `count_o` reads 0 in the same cycle. This holds whatever the values of `load_n_i` and both count clocks, and no count edge changes the value.
- R4: While `load_n_i` is low and `clr_i` is low, `count_o` equals `data_i` in the same cycle. Count-clock edges have no effect during that time.
- R5: `carry_n_o` is low exactly while the count is 15 and the synchronised up clock is low. It goes high again when that clock rises.
- R6: `borrow_n_o` is low exactly while the count is 0 and the synchronised down clock is low. It goes high again when that clock rises.
- R7: A count clock that is low during a clear or a load, and is still low after the release, has its next rising edge counted.
- R8: When rising edges on both count clocks are detected in the same system cycle, the count is unchanged and `clash_o` is high for that one cycle only.
- R9: Take a count-clock change applied before system edge k. With two synchronising stages, the terminal outputs follow it after edge k+1, and `count_o` takes the new value after edge k+2.
- R10: After system reset, `count_o` is 0, `carry_n_o` and `borrow_n_o` are high, and `clash_o` is low.
- R11: Two instances form an 8-bit counter when the upper stage's up and down clocks are fed from the lower stage's `carry_n_o` and `borrow_n_o`. This holds across wrap-around in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the count clocks |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| up_clk_i | input | 1 | Count-up clock; a rising edge increments |
| dn_clk_i | input | 1 | Count-down clock; a rising edge decrements |
| clr_i | input | 1 | Master clear, active high, highest priority |
| load_n_i | input | 1 | Parallel load, active low |
| data_i | input | WIDTH | Value taken by the counter during a load |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Up terminal strobe, active low |
| borrow_n_o | output | 1 | Down terminal strobe, active low |
| clash_o | output | 1 | High for one cycle when both count clocks rise together |

## Verification
Clear and load act on `count_o` in the same cycle. A count-clock change made before system edge k reaches the terminal outputs after edge k+1 and the count after edge k+2. A cascaded upper stage adds roughly two more edges on top of that. All inputs are driven on falling edges. The latency checks sample exactly two and then three falling edges after a change, which catches an extra or missing register stage. Table vectors and cascade pulses wait longer before sampling, so they are insensitive to the exact delay.

// File: rtl/updn_pkg.sv
package updn_pkg;

  // Decision taken by the counter core for one system cycle
  typedef enum logic [2:0] {
    STEP_HOLD  = 3'd0,
    STEP_INC   = 3'd1,
    STEP_DEC   = 3'd2,
    STEP_CLASH = 3'd3,
    STEP_CLEAR = 3'd4,
    STEP_LOAD  = 3'd5
  } step_e;

  localparam int unsigned DEF_WIDTH       = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/updn_rst_sync.sv
module updn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [1:0] chain_q;
  logic [1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 2'b00;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync_o = chain_q[1];

endmodule

// File: rtl/updn_edge_sampler.sv
module updn_edge_sampler #(
  parameter int unsigned STAGES = updn_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic lvl_o,
  output logic rise_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  // Shift chain; stage 0 takes the raw pin
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign sync_d[g] = lvl_i;
    end else begin : g_tail
      assign sync_d[g] = sync_q[g-1];
    end
  end

  always_comb begin
    prev_d = sync_q[LAST];
  end

  // Idle level of a count clock is high, so reset to 1: no false rise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign lvl_o  = sync_q[LAST];
  assign rise_o = sync_q[LAST] & ~prev_q;

  // A detected rise lasts a single system cycle (R9 timing)
  p_rise_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/updn_core.sv
module updn_core
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             rise_up_i,
  input  logic             rise_dn_i,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] cnt_q_o,
  output logic             clash_o
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  step_e            step;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  // Priority: clear, then load, then edges
  always_comb begin
    if (clr_i)                       step = STEP_CLEAR;
    else if (!load_n_i)              step = STEP_LOAD;
    else if (rise_up_i && rise_dn_i) step = STEP_CLASH;
    else if (rise_up_i)              step = STEP_INC;
    else if (rise_dn_i)              step = STEP_DEC;
    else                             step = STEP_HOLD;
  end

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (step)
      STEP_CLEAR: begin cnt_d = '0;          cnt_en = 1'b1; end
      STEP_LOAD:  begin cnt_d = data_i;      cnt_en = 1'b1; end
      STEP_INC:   begin cnt_d = cnt_q + ONE; cnt_en = 1'b1; end
      STEP_DEC:   begin cnt_d = cnt_q - ONE; cnt_en = 1'b1; end
      default:    begin cnt_d = cnt_q;       cnt_en = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Level overrides are visible at once on the output
  always_comb begin
    if (clr_i)          count_o = '0;
    else if (!load_n_i) count_o = data_i;
    else                count_o = cnt_q;
  end

  assign cnt_q_o = cnt_q;
  assign clash_o = (step == STEP_CLASH);

  p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  p_load_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !load_n_i) |=> (cnt_q == $past(data_i)));

  p_inc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && load_n_i && rise_up_i && !rise_dn_i) |=> (cnt_q == $past(cnt_q) + ONE));

  p_dec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && load_n_i && rise_dn_i && !rise_up_i) |=> (cnt_q == $past(cnt_q) - ONE));

  p_clash_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clash_o |=> $stable(cnt_q));

endmodule

// File: rtl/updn_term_gate.sv
module updn_term_gate #(
  parameter int unsigned WIDTH  = updn_pkg::DEF_WIDTH,
  parameter bit          AT_TOP = 1'b1
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             clk_lvl_i,
  output logic             tc_n_o
);

  logic [WIDTH-1:0] term_val;
  logic             at_term;

  if (AT_TOP) begin : g_top
    assign term_val = '1;
  end else begin : g_bottom
    assign term_val = '0;
  end

  always_comb begin
    at_term = (count_i == term_val);
    tc_n_o  = ~(at_term & ~clk_lvl_i);
  end

endmodule

// File: rtl/updn_ctr.sv
module updn_ctr #(
  parameter int unsigned WIDTH       = updn_pkg::DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = updn_pkg::DEF_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_clk_i,
  input  logic             dn_clk_i,
  input  logic             clr_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_n_o,
  output logic             borrow_n_o,
  output logic             clash_o
);

  localparam logic [WIDTH-1:0] TOP_VAL = '1;

  logic             rst_n_sync;
  logic             up_lvl, up_rise;
  logic             dn_lvl, dn_rise;
  logic [WIDTH-1:0] cnt_q;

  updn_rst_sync u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_sync)
  );

  updn_edge_sampler #(.STAGES(SYNC_STAGES)) u_up_smp (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .lvl_i  (up_clk_i),
    .lvl_o  (up_lvl),
    .rise_o (up_rise)
  );

  updn_edge_sampler #(.STAGES(SYNC_STAGES)) u_dn_smp (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .lvl_i  (dn_clk_i),
    .lvl_o  (dn_lvl),
    .rise_o (dn_rise)
  );

  updn_core #(.WIDTH(WIDTH)) u_core (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .clr_i     (clr_i),
    .load_n_i  (load_n_i),
    .data_i    (data_i),
    .rise_up_i (up_rise),
    .rise_dn_i (dn_rise),
    .count_o   (count_o),
    .cnt_q_o   (cnt_q),
    .clash_o   (clash_o)
  );

  updn_term_gate #(.WIDTH(WIDTH), .AT_TOP(1'b1)) u_carry (
    .count_i   (count_o),
    .clk_lvl_i (up_lvl),
    .tc_n_o    (carry_n_o)
  );

  updn_term_gate #(.WIDTH(WIDTH), .AT_TOP(1'b0)) u_borrow (
    .count_i   (count_o),
    .clk_lvl_i (dn_lvl),
    .tc_n_o    (borrow_n_o)
  );

  // Carry releasing on an up edge is followed by the wrap to zero
  p_carry_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($rose(carry_n_o) && up_rise && !dn_rise && !clr_i && load_n_i) |=> (cnt_q == '0));

  // Borrow releasing on a down edge is followed by the wrap to the top
  p_borrow_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($rose(borrow_n_o) && dn_rise && !up_rise && !clr_i && load_n_i) |=> (cnt_q == TOP_VAL));

  p_clash_single_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    clash_o |=> !clash_o);

endmodule

// File: tb/updn_ctr_bench.sv
module updn_ctr_bench;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         up, dn, clr, ld_n, hi_ld_n;
  logic [W-1:0] data, hi_data;
  logic [W-1:0] lo_cnt, hi_cnt;
  logic         lo_carry_n, lo_borrow_n, lo_clash;
  logic         hi_carry_n, hi_borrow_n, hi_clash;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  updn_ctr u_updn_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_clk_i   (up),
    .dn_clk_i   (dn),
    .clr_i      (clr),
    .load_n_i   (ld_n),
    .data_i     (data),
    .count_o    (lo_cnt),
    .carry_n_o  (lo_carry_n),
    .borrow_n_o (lo_borrow_n),
    .clash_o    (lo_clash)
  );

  updn_ctr u_stage_hi (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_clk_i   (lo_carry_n),
    .dn_clk_i   (lo_borrow_n),
    .clr_i      (clr),
    .load_n_i   (hi_ld_n),
    .data_i     (hi_data),
    .count_o    (hi_cnt),
    .carry_n_o  (hi_carry_n),
    .borrow_n_o (hi_borrow_n),
    .clash_o    (hi_clash)
  );

  // {clr, ld_n, up, dn, data[3:0], expected count[3:0]}
  localparam int NV = 19;
  localparam logic [11:0] VEC [NV] = '{
    {4'b0101, 4'd0,  4'd0},   // up low
    {4'b0111, 4'd0,  4'd1},   // up rise R1
    {4'b0101, 4'd0,  4'd1},
    {4'b0111, 4'd0,  4'd2},   // R1
    {4'b0011, 4'd14, 4'd14},  // load R4
    {4'b0111, 4'd0,  4'd14},
    {4'b0101, 4'd0,  4'd14},
    {4'b0111, 4'd0,  4'd15},
    {4'b0101, 4'd0,  4'd15},
    {4'b0111, 4'd0,  4'd0},   // wrap up R1
    {4'b0110, 4'd0,  4'd0},   // dn low
    {4'b0111, 4'd0,  4'd15},  // wrap down R2
    {4'b0110, 4'd0,  4'd15},
    {4'b0111, 4'd0,  4'd14},  // R2
    {4'b1011, 4'd9,  4'd0},   // clear beats load R3
    {4'b0011, 4'd9,  4'd9},   // R4
    {4'b0001, 4'd5,  4'd5},   // load, up low
    {4'b0011, 4'd5,  4'd5},   // up rise ignored under load R4
    {4'b0111, 4'd5,  4'd5}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    int limit = 20000;
    repeat (limit) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog (all) actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    int ref8;
    rst_n = 1'b0; up = 1'b1; dn = 1'b1; clr = 1'b0; ld_n = 1'b1;
    data = '0; hi_ld_n = 1'b0; hi_data = '0;
    settle(4);
    rst_n = 1'b1;
    settle(6);

    // R10 reset state
    chk("R10 count", int'(lo_cnt), 0);
    chk("R10 carry_n", int'(lo_carry_n), 1);
    chk("R10 borrow_n", int'(lo_borrow_n), 1);
    chk("R10 clash", int'(lo_clash), 0);

    // Vector table: R1 R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      clr  = VEC[i][11];
      ld_n = VEC[i][10];
      up   = VEC[i][9];
      dn   = VEC[i][8];
      data = VEC[i][7:4];
      settle(4);
      chk($sformatf("R1 R2 R3 R4 vector %0d", i), int'(lo_cnt), int'(VEC[i][3:0]));
    end

    // R5 and R9: carry strobe and latency
    ld_n = 1'b0; data = 4'd15; settle(2);
    ld_n = 1'b1; settle(3);
    chk("R5 carry idle at 15", int'(lo_carry_n), 1);
    up = 1'b0; settle(2);
    chk("R5 carry low", int'(lo_carry_n), 0);
    up = 1'b1; settle(2);
    chk("R5 carry released", int'(lo_carry_n), 1);
    chk("R9 count not yet stepped", int'(lo_cnt), 15);
    settle(1);
    chk("R9 count stepped", int'(lo_cnt), 0);

    // R6 and R9: borrow strobe
    dn = 1'b0; settle(2);
    chk("R6 borrow low", int'(lo_borrow_n), 0);
    chk("R5 carry high at 0", int'(lo_carry_n), 1);
    dn = 1'b1; settle(2);
    chk("R6 borrow released", int'(lo_borrow_n), 1);
    chk("R9 count not yet stepped", int'(lo_cnt), 0);
    settle(1);
    chk("R9 count wrapped down", int'(lo_cnt), 15);

    // R7: clock low across clear
    up = 1'b0; settle(3);
    clr = 1'b1; settle(3);
    chk("R3 clear", int'(lo_cnt), 0);
    clr = 1'b0; settle(3);
    up = 1'b1; settle(4);
    chk("R7 edge after clear", int'(lo_cnt), 1);

    // R7: clock low across load
    dn = 1'b0; settle(3);
    ld_n = 1'b0; data = 4'd7; settle(3);
    ld_n = 1'b1; settle(3);
    dn = 1'b1; settle(4);
    chk("R7 edge after load", int'(lo_cnt), 6);

    // R8: simultaneous rises
    up = 1'b0; dn = 1'b0; settle(3);
    up = 1'b1; dn = 1'b1; settle(2);
    chk("R8 clash raised", int'(lo_clash), 1);
    settle(1);
    chk("R8 clash one cycle", int'(lo_clash), 0);
    chk("R8 count held", int'(lo_cnt), 6);

    // R11: two-stage cascade against an 8-bit reference
    ld_n = 1'b0; data = '0; hi_ld_n = 1'b0; hi_data = '0; settle(3);
    ld_n = 1'b1; hi_ld_n = 1'b1; settle(4);
    ref8 = 0;
    for (int p = 0; p < 300; p++) begin
      up = 1'b0; settle(4);
      up = 1'b1; settle(7);
      ref8 = (ref8 + 1) % 256;
      chk($sformatf("R11 up pulse %0d", p), int'({hi_cnt, lo_cnt}), ref8);
    end
    for (int p = 0; p < 300; p++) begin
      dn = 1'b0; settle(4);
      dn = 1'b1; settle(7);
      ref8 = (ref8 + 255) % 256;
      chk($sformatf("R11 down pulse %0d", p), int'({hi_cnt, lo_cnt}), ref8);
    end

    done = 1'b1;
    report();
  end

endmodule